// File: doc/BRIEF.md
# Shared-Operand Matrix Multiply Engine

This block forms a series of square matrix products `C = A x B` with one signed multiplier and one accumulator. A host streams a per-job operand matrix into memory A. The second operand is a common factor matrix that goes into memory B once, on the first job after reset, and then serves every later job without being reloaded. A controller walks the result matrix element by element. For each element it runs an inner product over one row of A and one column of B, passes through a save step, and writes the saturated sum into memory C. When the whole matrix is written, it pulses a completion flag together with the job's index.

Every job starts from idle. The host raises the write strobe and the load select together and presents a job index. After that, each cycle in which the write strobe is high delivers one operand word. Words arrive in row-major order: first all of A, then all of B if the shared factor is not yet valid. The host reads results back through a synchronous read port on memory C. A `busy` output tells the host when the engine has left idle.

Top module: `shared_mm_engine`

## Requirements
- R1: While idle, the engine stays idle and `busy` stays low unless `wr_en` and `load_sel` are both 1 in the same cycle. That cycle captures `wr_index` and starts a job. `busy` is high in every other state.
- R2: After the start cycle, the engine accepts exactly N*N words into memory A, one word per cycle with `wr_en` high. The word with count r*N+c is element (r,c). Cycles with `wr_en` low write nothing and do not advance the count.
- R3: On the first job after reset, the engine then accepts N*N more words the same way into memory B and marks the shared factor valid.
- R4: When the shared factor is valid, the engine goes straight from the last A word to the multiply phase. Memory B is never written again until reset, even if the host drives `wr_en` and data during the job.
- R5: Result element (r,c) equals the sum over k = 0..N-1 of A[r][k]*B[k][c]. All operands are two's-complement signed with DW bits. The result is stored at C address r*N+c.
- R6: The accumulator restarts from zero for every result element, so no partial sum carries over from one element or one job into another.
- R7: A sum above 2^(OW-1)-1 is stored as 2^(OW-1)-1. A sum below -2^(OW-1) is stored as -2^(OW-1).
- R8: After the last result is written, `done` is high for exactly one cycle and `done_index` shows the captured job index. The next cycle the engine is idle.
- R9: `done` rises N*N*(N+2) clock edges after the edge that accepts the last operand word of the job. Each element takes N multiply steps, one save step and one write step.
- R10: `rd_data` shows memory C at `rd_addr` one cycle after the address is presented. Results stay there until a later job overwrites them.
- R11: Reset returns the engine to idle and clears the shared-valid mark, so the next job loads memory B again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe: starts a job in idle, delivers one operand word per cycle while loading |
| load_sel | input | 1 | Must be 1 together with `wr_en` to start a job |
| wr_index | input | IW | Job index, captured at start |
| wr_data | input | DW | Signed operand word |
| busy | output | 1 | High whenever the engine is not idle |
| done | output | 1 | One-cycle pulse when a result matrix is complete |
| done_index | output | IW | Index of the completed job |
| rd_addr | input | 2*log2(N) | Result read address, row-major |
| rd_data | output | OW | Signed result at `rd_addr`, one cycle later |

## Verification
The bench builds the engine with N=4, DW=8, OW=12 and IW=4. This gives 16-entry memories and six-cycle result elements, so one job is short enough to run many jobs in one run, including a reset partway through. With 8-bit operands, full-range products summed over four terms far exceed the 12-bit output, so both saturation limits are reached easily. Small random operands keep sums exact, so plain accumulation is checked separately from clamping. The completion latency is checked against the N*N*(N+2) formula for jobs that load B and for jobs that skip it.

// File: rtl/smm_pkg.sv
package smm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_A,
        ST_LOAD_B,
        ST_MUL,
        ST_SAVE,
        ST_WRC,
        ST_DONE
    } smm_state_e;

    // Accumulator commands from the controller
    typedef struct packed {
        logic clr;
        logic add;
    } mac_ctl_t;

endpackage

// File: rtl/smm_mem.sv
module smm_mem #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/smm_mac.sv
module smm_mac
    import smm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int OW   = 24,
    parameter int ACCW = 38
) (
    input  logic          clk,
    input  logic          rst,
    input  mac_ctl_t      ctl,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic [OW-1:0] sat_out
);
    localparam int PW = 2 * DW;
    localparam logic signed [ACCW-1:0] MAXV = {{(ACCW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] MINV = ~MAXV;

    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] prod_ext;
    logic signed [ACCW-1:0] acc;

    assign prod     = $signed(a_in) * $signed(b_in);
    assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (ctl.clr) begin
            acc <= '0;
        end else if (ctl.add) begin
            acc <= acc + prod_ext;
        end
    end

    always_comb begin
        if (acc > MAXV) begin
            sat_out = MAXV[OW-1:0];
        end else if (acc < MINV) begin
            sat_out = MINV[OW-1:0];
        end else begin
            sat_out = acc[OW-1:0];
        end
    end
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl
    import smm_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = 6,
    parameter int KW = $clog2(N),
    parameter int EW = 2 * KW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          load_sel,
    input  logic [IW-1:0] wr_index,
    output logic          a_we,
    output logic          b_we,
    output logic [EW-1:0] ld_addr,
    output logic [EW-1:0] a_raddr,
    output logic [EW-1:0] b_raddr,
    output logic          c_we,
    output logic [EW-1:0] c_waddr,
    output mac_ctl_t      mac_ctl,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] done_index
);
    localparam logic [EW-1:0] LAST_E = EW'(N * N - 1);
    localparam logic [KW-1:0] LAST_K = KW'(N - 1);

    smm_state_e    state;
    logic [EW-1:0] ld_cnt;
    logic [EW-1:0] elem;
    logic [KW-1:0] k_cnt;
    logic          shared_v;
    logic [IW-1:0] idx_q;
    logic [KW-1:0] row;
    logic [KW-1:0] col;

    assign row = elem[EW-1:KW];
    assign col = elem[KW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ld_cnt   <= '0;
            elem     <= '0;
            k_cnt    <= '0;
            shared_v <= 1'b0;
            idx_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (wr_en && load_sel) begin
                        idx_q  <= wr_index;
                        ld_cnt <= '0;
                        elem   <= '0;
                        k_cnt  <= '0;
                        state  <= ST_LOAD_A;
                    end
                end
                ST_LOAD_A: begin
                    if (wr_en) begin
                        if (ld_cnt == LAST_E) begin
                            ld_cnt <= '0;
                            state  <= shared_v ? ST_MUL : ST_LOAD_B;
                        end else begin
                            ld_cnt <= ld_cnt + 1'b1;
                        end
                    end
                end
                ST_LOAD_B: begin
                    if (wr_en) begin
                        if (ld_cnt == LAST_E) begin
                            ld_cnt   <= '0;
                            shared_v <= 1'b1;
                            state    <= ST_MUL;
                        end else begin
                            ld_cnt <= ld_cnt + 1'b1;
                        end
                    end
                end
                ST_MUL: begin
                    if (k_cnt == LAST_K) begin
                        k_cnt <= '0;
                        state <= ST_SAVE;
                    end else begin
                        k_cnt <= k_cnt + 1'b1;
                    end
                end
                ST_SAVE: state <= ST_WRC;
                ST_WRC: begin
                    if (elem == LAST_E) begin
                        elem  <= '0;
                        state <= ST_DONE;
                    end else begin
                        elem  <= elem + 1'b1;
                        state <= ST_MUL;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Reads are issued in MUL; the product of step k reaches the adder one cycle later
    assign a_we        = (state == ST_LOAD_A) && wr_en;
    assign b_we        = (state == ST_LOAD_B) && wr_en;
    assign ld_addr     = ld_cnt;
    assign a_raddr     = {row, k_cnt};
    assign b_raddr     = {k_cnt, col};
    assign c_we        = (state == ST_WRC);
    assign c_waddr     = elem;
    assign mac_ctl.clr = (state == ST_MUL) && (k_cnt == '0);
    assign mac_ctl.add = ((state == ST_MUL) && (k_cnt != '0)) || (state == ST_SAVE);
    assign busy        = (state != ST_IDLE);
    assign done        = (state == ST_DONE);
    assign done_index  = idx_q;

    // R1: no start without both qualifiers
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !(wr_en && load_sel)) |=> (state == ST_IDLE));

    // R4: shared factor memory is frozen once valid
    p_shared_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        shared_v |-> !b_we);

    // R4: last A word goes straight to multiply when factor is valid
    p_skip_b_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD_A && wr_en && ld_cnt == LAST_E && shared_v) |=> (state == ST_MUL));

    // R5: save follows a complete inner product
    p_inner_len_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SAVE) |-> ($past(state) == ST_MUL && $past(k_cnt) == LAST_K));

    // R5: memory C is written only right after a save step
    p_save_first_r5: assert property (@(posedge clk) disable iff (rst)
        c_we |-> ($past(state) == ST_SAVE));

    // R8: completion returns to idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == ST_IDLE && !done));
endmodule

// File: rtl/shared_mm_engine.sv
module shared_mm_engine
    import smm_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 16,
    parameter int OW = 24,
    parameter int IW = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       load_sel,
    input  logic [IW-1:0]              wr_index,
    input  logic [DW-1:0]              wr_data,
    output logic                       busy,
    output logic                       done,
    output logic [IW-1:0]              done_index,
    input  logic [2*$clog2(N)-1:0]     rd_addr,
    output logic [OW-1:0]              rd_data
);
    localparam int KW    = $clog2(N);
    localparam int EW    = 2 * KW;
    localparam int DEPTH = N * N;
    localparam int ACCW  = 2 * DW + KW + 1;

    logic          a_we, b_we, c_we;
    logic [EW-1:0] ld_addr, a_raddr, b_raddr, c_waddr;
    logic [DW-1:0] a_q, b_q;
    logic [OW-1:0] sat_out;
    mac_ctl_t      mac_ctl;

    smm_ctrl #(.N(N), .IW(IW), .KW(KW), .EW(EW)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .load_sel(load_sel), .wr_index(wr_index),
        .a_we(a_we), .b_we(b_we), .ld_addr(ld_addr), .a_raddr(a_raddr), .b_raddr(b_raddr),
        .c_we(c_we), .c_waddr(c_waddr), .mac_ctl(mac_ctl), .busy(busy), .done(done),
        .done_index(done_index)
    );

    smm_mem #(.DEPTH(DEPTH), .WIDTH(DW), .AW(EW)) u_mem_a (
        .clk(clk), .we(a_we), .waddr(ld_addr), .wdata(wr_data), .raddr(a_raddr), .rdata(a_q)
    );

    smm_mem #(.DEPTH(DEPTH), .WIDTH(DW), .AW(EW)) u_mem_b (
        .clk(clk), .we(b_we), .waddr(ld_addr), .wdata(wr_data), .raddr(b_raddr), .rdata(b_q)
    );

    smm_mac #(.DW(DW), .OW(OW), .ACCW(ACCW)) u_mac (
        .clk(clk), .rst(rst), .ctl(mac_ctl), .a_in(a_q), .b_in(b_q), .sat_out(sat_out)
    );

    smm_mem #(.DEPTH(DEPTH), .WIDTH(OW), .AW(EW)) u_mem_c (
        .clk(clk), .we(c_we), .waddr(c_waddr), .wdata(sat_out), .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: tb/shared_mm_engine_bench.sv
module shared_mm_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int OW = 12;
    localparam int IW = 4;
    localparam int NE = N * N;
    localparam int EW = 2 * $clog2(N);
    localparam int LAT = NE * (N + 2) + 1; // negedges counted from the accepting edge

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          load_sel = 1'b0;
    logic [IW-1:0] wr_index = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy, done;
    logic [IW-1:0] done_index;
    logic [EW-1:0] rd_addr = '0;
    logic [OW-1:0] rd_data;

    shared_mm_engine #(.N(N), .DW(DW), .OW(OW), .IW(IW)) u_shared_mm_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .load_sel(load_sel), .wr_index(wr_index),
        .wr_data(wr_data), .busy(busy), .done(done), .done_index(done_index),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ma [NE];
    int mb [NE];

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog R8: got no finish, expected finish before %0d cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(string req, string what, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int sat(longint v);
        longint hi = (longint'(1) <<< (OW - 1)) - 1;
        longint lo = -(longint'(1) <<< (OW - 1));
        if (v > hi) return int'(hi);
        if (v < lo) return int'(lo);
        return int'(v);
    endfunction

    function automatic int exp_c(int e);
        longint s = 0;
        for (int k = 0; k < N; k++) s += longint'(ma[(e / N) * N + k]) * longint'(mb[k * N + (e % N)]);
        return sat(s);
    endfunction

    function automatic int rnd(bit full);
        if (full) return int'($urandom_range(255)) - 128;
        return int'($urandom_range(30)) - 15;
    endfunction

    task automatic put_word(int v);
        @(negedge clk);
        load_sel = 1'b0;
        if ($urandom_range(3) == 0) begin // R2: idle gap, must not advance
            wr_en   = 1'b0;
            wr_data = DW'($urandom);
            @(negedge clk);
        end
        wr_en   = 1'b1;
        wr_data = DW'(v);
    endtask

    task automatic read_all();
        for (int e = 0; e < NE; e++) begin
            @(negedge clk);
            rd_addr = EW'(e);
            @(negedge clk);
            check("R5", $sformatf("C[%0d]", e), int'($signed(rd_data)), exp_c(e));
        end
    endtask

    task automatic run_job(int idx, bit load_b, bit noise);
        int cnt;
        @(negedge clk);
        wr_en = 1'b1; load_sel = 1'b1; wr_index = IW'(idx);
        for (int i = 0; i < NE; i++) put_word(ma[i]);
        if (load_b) for (int i = 0; i < NE; i++) put_word(mb[i]);
        @(negedge clk);
        cnt = 1;
        wr_en = noise; load_sel = 1'b0; wr_data = DW'($urandom); // R4: noise must not reach B
        while (!done && cnt < 5000) begin
            @(negedge clk);
            cnt++;
            if (noise) wr_data = DW'($urandom);
        end
        check("R9", "latency to done", cnt, LAT);
        check("R8", "done_index", int'(done_index), idx);
        check("R1", "busy during done", int'(busy), 1);
        wr_en = 1'b0;
        @(negedge clk);
        check("R8", "done width", int'(done), 0);
        check("R1", "busy after done", int'(busy), 0);
        read_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; load_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11", "busy in reset state", int'(busy), 0);
        check("R11", "done in reset state", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R1: one qualifier alone does not start
        wr_en = 1'b1; load_sel = 1'b0; wr_data = 8'h55;
        repeat (4) begin @(negedge clk); check("R1", "busy wr_en only", int'(busy), 0); end
        wr_en = 1'b0; load_sel = 1'b1;
        repeat (4) begin @(negedge clk); check("R1", "busy load_sel only", int'(busy), 0); end
        load_sel = 1'b0;

        // R3 R5 R6: first job loads the shared factor
        for (int i = 0; i < NE; i++) begin ma[i] = rnd(0); mb[i] = rnd(0); end
        run_job(3, 1'b1, 1'b0);

        // R4: second job skips B, host noise during multiply
        for (int i = 0; i < NE; i++) ma[i] = rnd(0);
        run_job(5, 1'b0, 1'b1);

        // R10: results held while idle with unrelated traffic
        wr_en = 1'b1; load_sel = 1'b0;
        repeat (5) begin @(negedge clk); wr_data = DW'($urandom); end
        wr_en = 1'b0;
        @(negedge clk); rd_addr = EW'(NE - 1);
        @(negedge clk); check("R10", "held C[last]", int'($signed(rd_data)), exp_c(NE - 1));
        rd_addr = '0;
        @(negedge clk); check("R10", "held C[0]", int'($signed(rd_data)), exp_c(0));

        // R11: reset clears shared valid; R7 directed saturation
        do_reset();
        for (int i = 0; i < NE; i++) begin
            ma[i] = 127;
            case (i % N)
                0: mb[i] = 127;
                1: mb[i] = -128;
                2: mb[i] = 0;
                default: mb[i] = (i / N) - 1;
            endcase
        end
        run_job(7, 1'b1, 1'b0);
        check("R7", "positive clamp", exp_c(0), (1 << (OW - 1)) - 1);
        check("R7", "negative clamp", exp_c(1), -(1 << (OW - 1)));

        // R7 R5: full-range random operands with shared B
        for (int i = 0; i < NE; i++) ma[i] = rnd(1);
        run_job(9, 1'b0, 1'b1);

        // R6 R5: more random jobs
        for (int j = 0; j < 4; j++) begin
            for (int i = 0; i < NE; i++) ma[i] = rnd(j[0]);
            run_job(j + 10, 1'b0, j[1]);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule